// File: doc/BRIEF.md
# Load-Balancing Time-Division Crossbar

This block is the first stage of a two-stage load-balanced switch. It sits behind the per-input packet queues. It spreads each input's packets evenly over all intermediate ports by following a fixed rotating connection pattern. Time is divided into slots of `SLOT_BEATS` cycles, and one slot carries exactly one fixed-size packet: with the default 16-bit path, a 64-byte packet takes 32 beats. In slot `k`, input `i` is connected to output `(i + k) mod PORTS`. The slot index advances only when a slot ends, so a packet is never split across two connection patterns.

An input offers a packet by raising its valid line and presenting the packet's destination on the first beat of a slot. This beat is marked by `slot_start`. If it does so, the block forwards all beats of that slot to the connected output. It attaches the destination and a per-(input, destination) sequence number, which the later reordering stage uses. An input that is idle on the first beat gives an idle output for the whole slot. The upstream queue uses `slot_start` to align its packets to slot boundaries.

Top module: `tdm_lb_crossbar`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every `out_valid` bit is 0. The first cycle after reset is beat 0 of slot 0, so `slot_start` is 1 and `slot_idx` is 0.
- R2: A beat presented on input `i` during slot `k` appears one clock later on output `(i + k) mod PORTS`, with the same data.
- R3: `slot_idx` holds for `SLOT_BEATS` cycles and then increments by one. It wraps from `PORTS-1` to 0.
- R4: An input is accepted for a slot only if `in_valid` is 1 on that slot's first beat. Otherwise its output shows `out_valid` = 0 for every beat of the slot, even if `in_valid` rises later in the slot.
- R5: For an accepted input, the connected output shows `out_valid` = 1 on all `SLOT_BEATS` beats of the slot, whatever `in_valid` does after the first beat.
- R6: `out_dest` equals the `in_dest` sampled on the slot's first beat. It stays unchanged for the whole packet even if `in_dest` changes later in the slot.
- R7: Every input keeps one `SEQ_W`-bit counter per destination, cleared by reset. An accepted packet is tagged with the current counter value for its destination, and only that counter then increments, wrapping modulo 2^SEQ_W.
- R8: Whenever `out_valid` is 0, `out_data`, `out_dest` and `out_seq` of that output are all 0.
- R9: `slot_start` is 1 exactly on the first beat of each slot. This is the cycle in which offers and destinations are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | PORTS | Per-input packet present; sampled on the first beat |
| in_dest | input | PORTS x log2(PORTS) | Per-input destination port; sampled on the first beat |
| in_data | input | PORTS x DATA_W | Per-input packet beat |
| slot_start | output | 1 | First beat of the current slot |
| slot_idx | output | log2(PORTS) | Current rotation offset k |
| out_valid | output | PORTS | Output lane carries a packet beat |
| out_data | output | PORTS x DATA_W | Output lane beat |
| out_dest | output | PORTS x log2(PORTS) | Destination tag of the packet on the lane |
| out_seq | output | PORTS x SEQ_W | Sequence tag of the packet on the lane |

## Verification
The case hardest to reach from the ports is wrap-around of a single sequence counter. It needs 2^SEQ_W accepted packets from one input to one destination. The stimulus gets there with a long run of slots in which every input sends to destination 0, while the scoreboard's own counters follow the modulo arithmetic. Valid and destination lines that change in the middle of a slot are the other awkward case. Randomized slots raise `in_valid` late on idle inputs, drop it early on busy ones, and scramble `in_dest` after the first beat, so the latching on the first beat is tested on all eight rotations.

// File: rtl/tdm_lb_pkg.sv
package tdm_lb_pkg;

    // Input lane feeding a given output lane when the rotation offset is slot.
    function automatic int rot_source(int out_port, int slot, int ports);
        return (out_port + ports - (slot % ports)) % ports;
    endfunction

    // Increment with wrap at lim.
    function automatic int wrap_next(int value, int lim);
        return (value + 1 >= lim) ? 0 : value + 1;
    endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter int PORTS      = 8,
    parameter int SLOT_BEATS = 32,
    localparam int BEAT_W    = $clog2(SLOT_BEATS),
    localparam int PORT_W    = $clog2(PORTS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              slot_first,
    output logic [PORT_W-1:0] slot_idx
);
    import tdm_lb_pkg::*;

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(SLOT_BEATS - 1);

    logic [BEAT_W-1:0] beat_q;
    logic [PORT_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            slot_q <= '0;
        end else if (beat_q == LAST_BEAT) begin
            beat_q <= '0;
            slot_q <= PORT_W'(wrap_next(int'(slot_q), PORTS));
        end else begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign slot_first = (beat_q == '0);
    assign slot_idx   = slot_q;

endmodule

// File: rtl/tdm_ingress_tag.sv
module tdm_ingress_tag #(
    parameter int PORTS   = 8,
    parameter int DATA_W  = 16,
    parameter int SEQ_W   = 8,
    localparam int PORT_W = $clog2(PORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_first,
    input  logic              in_valid,
    input  logic [PORT_W-1:0] in_dest,
    input  logic [DATA_W-1:0] in_data,
    output logic              cell_valid,
    output logic [DATA_W-1:0] cell_data,
    output logic [PORT_W-1:0] cell_dest,
    output logic [SEQ_W-1:0]  cell_seq
);
    typedef struct packed {
        logic              valid;
        logic [PORT_W-1:0] dest;
        logic [SEQ_W-1:0]  seq;
    } tag_t;

    logic [PORTS-1:0][SEQ_W-1:0] seq_q;
    tag_t hold_q;
    tag_t live;

    // First beat takes a fresh tag; later beats reuse the latched one.
    always_comb begin
        if (slot_first) begin
            live.valid = in_valid;
            live.dest  = in_dest;
            live.seq   = seq_q[in_dest];
        end else begin
            live = hold_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            seq_q  <= '0;
        end else if (slot_first) begin
            hold_q <= live;
            if (in_valid) begin
                seq_q[in_dest] <= seq_q[in_dest] + 1'b1;
            end
        end
    end

    assign cell_valid = live.valid;
    assign cell_data  = live.valid ? in_data   : '0;
    assign cell_dest  = live.valid ? live.dest : '0;
    assign cell_seq   = live.valid ? live.seq  : '0;

endmodule

// File: rtl/tdm_rotator.sv
module tdm_rotator #(
    parameter int PORTS   = 8,
    parameter int DATA_W  = 16,
    parameter int SEQ_W   = 8,
    localparam int PORT_W = $clog2(PORTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [PORT_W-1:0]             slot_idx,
    input  logic [PORTS-1:0]              cell_valid,
    input  logic [PORTS-1:0][DATA_W-1:0]  cell_data,
    input  logic [PORTS-1:0][PORT_W-1:0]  cell_dest,
    input  logic [PORTS-1:0][SEQ_W-1:0]   cell_seq,
    output logic [PORTS-1:0]              out_valid,
    output logic [PORTS-1:0][DATA_W-1:0]  out_data,
    output logic [PORTS-1:0][PORT_W-1:0]  out_dest,
    output logic [PORTS-1:0][SEQ_W-1:0]   out_seq
);
    import tdm_lb_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [PORT_W-1:0] dest;
        logic [SEQ_W-1:0]  seq;
    } lane_t;

    lane_t [PORTS-1:0] pick;
    lane_t [PORTS-1:0] lane_q;

    always_comb begin
        for (int o = 0; o < PORTS; o++) begin
            int src;
            src = rot_source(o, int'(slot_idx), PORTS);
            pick[o].valid = cell_valid[src];
            pick[o].data  = cell_data[src];
            pick[o].dest  = cell_dest[src];
            pick[o].seq   = cell_seq[src];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
        end else begin
            lane_q <= pick;
        end
    end

    for (genvar o = 0; o < PORTS; o++) begin : g_out
        assign out_valid[o] = lane_q[o].valid;
        assign out_data[o]  = lane_q[o].data;
        assign out_dest[o]  = lane_q[o].dest;
        assign out_seq[o]   = lane_q[o].seq;
    end

endmodule

// File: rtl/tdm_lb_crossbar.sv
module tdm_lb_crossbar #(
    parameter int PORTS      = 8,
    parameter int DATA_W     = 16,
    parameter int SLOT_BEATS = 32,
    parameter int SEQ_W      = 8,
    localparam int PORT_W    = $clog2(PORTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [PORTS-1:0]              in_valid,
    input  logic [PORTS-1:0][PORT_W-1:0]  in_dest,
    input  logic [PORTS-1:0][DATA_W-1:0]  in_data,
    output logic                          slot_start,
    output logic [PORT_W-1:0]             slot_idx,
    output logic [PORTS-1:0]              out_valid,
    output logic [PORTS-1:0][DATA_W-1:0]  out_data,
    output logic [PORTS-1:0][PORT_W-1:0]  out_dest,
    output logic [PORTS-1:0][SEQ_W-1:0]   out_seq
);
    logic                         slot_first;
    logic [PORT_W-1:0]            slot_k;
    logic [PORTS-1:0]             cell_valid;
    logic [PORTS-1:0][DATA_W-1:0] cell_data;
    logic [PORTS-1:0][PORT_W-1:0] cell_dest;
    logic [PORTS-1:0][SEQ_W-1:0]  cell_seq;

    tdm_slot_timer #(.PORTS(PORTS), .SLOT_BEATS(SLOT_BEATS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .slot_first (slot_first),
        .slot_idx   (slot_k)
    );

    for (genvar i = 0; i < PORTS; i++) begin : g_in
        tdm_ingress_tag #(.PORTS(PORTS), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_tag (
            .clk        (clk),
            .rst        (rst),
            .slot_first (slot_first),
            .in_valid   (in_valid[i]),
            .in_dest    (in_dest[i]),
            .in_data    (in_data[i]),
            .cell_valid (cell_valid[i]),
            .cell_data  (cell_data[i]),
            .cell_dest  (cell_dest[i]),
            .cell_seq   (cell_seq[i])
        );
    end

    tdm_rotator #(.PORTS(PORTS), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_rot (
        .clk        (clk),
        .rst        (rst),
        .slot_idx   (slot_k),
        .cell_valid (cell_valid),
        .cell_data  (cell_data),
        .cell_dest  (cell_dest),
        .cell_seq   (cell_seq),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_dest   (out_dest),
        .out_seq    (out_seq)
    );

    assign slot_start = slot_first;
    assign slot_idx   = slot_k;

endmodule

// File: rtl/tdm_lb_checker.sv
module tdm_lb_checker #(
    parameter int PORTS      = 8,
    parameter int DATA_W     = 16,
    parameter int SLOT_BEATS = 32,
    parameter int SEQ_W      = 8,
    localparam int PORT_W    = $clog2(PORTS)
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          slot_start,
    input logic [PORT_W-1:0]             slot_idx,
    input logic [PORTS-1:0]              out_valid,
    input logic [PORTS-1:0][DATA_W-1:0]  out_data,
    input logic [PORTS-1:0][PORT_W-1:0]  out_dest,
    input logic [PORTS-1:0][SEQ_W-1:0]   out_seq
);
    logic started;
    logic lead_beat;   // output cycle that carries beat 0 of a slot

    always_ff @(posedge clk) begin
        if (rst) begin
            started   <= 1'b0;
            lead_beat <= 1'b0;
        end else begin
            started   <= 1'b1;
            lead_beat <= slot_start;
        end
    end

    // R9: a slot start is never followed by another one on the next cycle
    a_r9_start_spacing: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> !slot_start);

    // R3: offset steps by one, modulo PORTS, at each slot start
    a_r3_slot_step: assert property (@(posedge clk) disable iff (rst)
        (slot_start && started) |-> int'(slot_idx) == (int'($past(slot_idx)) + 1) % PORTS);

    // R3: offset is frozen inside a slot
    a_r3_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (!slot_start && started) |-> $stable(slot_idx));

    for (genvar o = 0; o < PORTS; o++) begin : g_lane
        // R8: idle lanes carry zeros
        a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
            !out_valid[o] |-> (out_data[o] == '0 && out_dest[o] == '0 && out_seq[o] == '0));

        // R4, R5: lane validity only changes on the lead beat of a slot
        a_r5_valid_hold: assert property (@(posedge clk) disable iff (rst)
            (!lead_beat && started) |-> $stable(out_valid[o]));

        // R6, R7: tags stay fixed across the beats of a packet
        a_r6_tag_stable: assert property (@(posedge clk) disable iff (rst)
            (out_valid[o] && !lead_beat && started) |-> ($stable(out_dest[o]) && $stable(out_seq[o])));
    end

endmodule

bind tdm_lb_crossbar tdm_lb_checker #(
    .PORTS(PORTS), .DATA_W(DATA_W), .SLOT_BEATS(SLOT_BEATS), .SEQ_W(SEQ_W)
) u_chk (.*);

// File: tb/tb_tdm_lb_crossbar.sv
`timescale 1ns/1ps
module tb_tdm_lb_crossbar;
    localparam int NP = 8;
    localparam int DW = 16;
    localparam int SB = 32;
    localparam int SW = 8;
    localparam int PW = 3;

    typedef struct packed {
        logic          v;
        logic [DW-1:0] d;
        logic [PW-1:0] dst;
        logic [SW-1:0] s;
    } cell_t;
    typedef cell_t [NP-1:0] row_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0]         in_valid = '0;
    logic [NP-1:0][PW-1:0] in_dest = '0;
    logic [NP-1:0][DW-1:0] in_data = '0;
    logic                  slot_start;
    logic [PW-1:0]         slot_idx;
    logic [NP-1:0]         out_valid;
    logic [NP-1:0][DW-1:0] out_data;
    logic [NP-1:0][PW-1:0] out_dest;
    logic [NP-1:0][SW-1:0] out_seq;

    tdm_lb_crossbar #(.PORTS(NP), .DATA_W(DW), .SLOT_BEATS(SB), .SEQ_W(SW)) dut (.*);

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    row_t exp_q[$];

    // bench model state
    int model_k = 0;
    int seqc[NP][NP];
    bit hv[NP];
    int hd[NP];
    int hs[NP];
    int slot_no = 0;
    bit plan_v[NP];
    int plan_d[NP];
    bit plan_late[NP];
    bit plan_drop[NP];
    logic [31:0] lfsr = 32'h1234_5678;

    function automatic int rnd(int m);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return int'(lfsr[15:0]) % m;
    endfunction

    task automatic report(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Driver: one slot of SB beats; drives inputs and pushes expected rows
    task automatic run_slot();
        for (int b = 0; b < SB; b++) begin
            row_t row;
            @(negedge clk);
            rst = 1'b0;
            report(slot_start == (b == 0), (slot_no == 0 && b == 0) ? "R1" : "R9",
                   "slot_start", int'(slot_start), int'(b == 0));
            report(int'(slot_idx) == model_k, (slot_no == 0) ? "R1" : "R3",
                   "slot_idx", int'(slot_idx), model_k);
            for (int i = 0; i < NP; i++) begin
                if (b == 0) begin
                    hv[i] = plan_v[i];
                    hd[i] = plan_d[i];
                    hs[i] = seqc[i][plan_d[i]];
                    if (plan_v[i]) seqc[i][plan_d[i]] = (seqc[i][plan_d[i]] + 1) % 256;
                    in_valid[i] = plan_v[i];
                    in_dest[i]  = PW'(plan_d[i]);
                end else begin
                    // R4/R5/R6: mid-slot valid and dest wiggles must be ignored
                    in_valid[i] = hv[i] ? !(plan_drop[i] && b >= 16) : (plan_late[i] && b >= 8);
                    in_dest[i]  = PW'(~plan_d[i] + b);
                end
                in_data[i] = DW'((i << 12) | ((slot_no & 15) << 8) | (b << 1) | 1);
            end
            for (int o = 0; o < NP; o++) begin
                int src = (o + NP - model_k) % NP;
                row[o].v   = hv[src];
                row[o].d   = hv[src] ? in_data[src] : '0;
                row[o].dst = hv[src] ? PW'(hd[src]) : '0;
                row[o].s   = hv[src] ? SW'(hs[src]) : '0;
            end
            exp_q.push_back(row);
        end
        model_k = (model_k + 1) % NP;
        slot_no++;
    endtask

    // Monitor: compares each output lane one clock after its beat was driven
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                row_t e;
                e = exp_q.pop_front();
                for (int o = 0; o < NP; o++) begin
                    cell_t a;
                    a = '{out_valid[o], out_data[o], out_dest[o], out_seq[o]};
                    if (a.v != e[o].v)
                        report(0, e[o].v ? "R5" : "R4", "out_valid", int'(a.v), int'(e[o].v));
                    else if (a.d != e[o].d)
                        report(0, e[o].v ? "R2" : "R8", "out_data", int'(a.d), int'(e[o].d));
                    else if (a.dst != e[o].dst)
                        report(0, e[o].v ? "R6" : "R8", "out_dest", int'(a.dst), int'(e[o].dst));
                    else if (a.s != e[o].s)
                        report(0, e[o].v ? "R7" : "R8", "out_seq", int'(a.s), int'(e[o].s));
                    else
                        report(1, "R2", "lane", 0, 0);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++)
            for (int d = 0; d < NP; d++) seqc[i][d] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        report(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);

        // distinct destinations, all inputs busy
        for (int i = 0; i < NP; i++) begin
            plan_v[i] = 1; plan_d[i] = i; plan_late[i] = 0; plan_drop[i] = 0;
        end
        run_slot();
        // all idle with late valid raise (R4)
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < NP; i++) begin
                plan_v[i] = 0; plan_d[i] = i; plan_late[i] = 1; plan_drop[i] = 0;
            end
            run_slot();
        end
        // randomized slots over many rotations
        for (int s = 0; s < 24; s++) begin
            for (int i = 0; i < NP; i++) begin
                plan_v[i]    = rnd(4) != 0;
                plan_d[i]    = rnd(NP);
                plan_late[i] = rnd(2) == 1;
                plan_drop[i] = rnd(2) == 1;
            end
            run_slot();
        end
        // R7: long run to one destination forces counter wrap
        for (int s = 0; s < 262; s++) begin
            for (int i = 0; i < NP; i++) begin
                plan_v[i] = 1; plan_d[i] = 0; plan_late[i] = 0; plan_drop[i] = (s % 3 == 0);
            end
            run_slot();
        end
        // other destinations keep their own counts after the wrap
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < NP; i++) begin
                plan_v[i] = 1; plan_d[i] = (i + s) % NP; plan_late[i] = 0; plan_drop[i] = 0;
            end
            run_slot();
        end
        @(negedge clk);
        in_valid = '0;
        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule